// File: doc/BRIEF.md
# I2C Target Write Receiver with Clock Stretching

This block is the receive side of an I2C target. It follows SCL and SDA through a two-stage synchronizer, detects start and stop conditions, and shifts in bytes MSB first on each SCL rising edge. The first byte after a start carries a 7-bit address and a direction bit. It is accepted only when the address equals `dev_addr_i` and the direction bit is 0, which means a write. On every accepted byte the block drives SDA low during the ninth clock when `ack_en_i` is set, and leaves SDA released otherwise, so the sender sees a NACK.

When the ninth clock falls, the block publishes the byte on `rx_data_o`, pulses `byte_done_o` and holds SCL low. The sender then waits. Local logic reads the byte and frees the bus in one of two ways: it pulses `release_i`, or it writes 0xFF through `wr_en_i`/`wr_data_i`. A write of any other value leaves the hold in place. A stop condition pulses `stop_o` and returns the block to idle. Both bus outputs are drive-low enables for open-drain pads. A 1 pulls the line low and a 0 releases it, so the block never drives a line high.

The controller has six states:
- IDLE waits for a start.
- ADDR shifts in the address byte.
- DATA shifts in a data byte.
- ACK covers the ninth clock.
- HOLD stretches SCL.
- SKIP ignores the bus after an address that does not match.

The transitions are:
- start (from any state) goes to ADDR.
- stop (from any state) goes to IDLE.
- ADDR moves to ACK on the eighth falling edge when the address matches, and to SKIP when it does not.
- DATA moves to ACK on the eighth falling edge.
- ACK moves to HOLD on the ninth falling edge.
- HOLD moves to DATA on a release request.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset `scl_drive_low_o`, `sda_drive_low_o`, `byte_done_o` and `stop_o` are 0, and `rx_data_o` is 0x00.
- R2: Bits are captured MSB first on SCL rising edges. When the ninth clock of an accepted byte falls, `rx_data_o` takes the eight captured bits and keeps them until the next accepted byte.
- R3: An address byte is accepted only when bits [7:1] equal `dev_addr_i` and bit 0 is 0. Otherwise the block sends no ACK, applies no hold and raises no `byte_done_o` until the next start, and `rx_data_o` stays unchanged.
- R4: On the ninth clock of an accepted byte, SDA is pulled low (`sda_drive_low_o`=1) when `ack_en_i` was 1 at the end of the eighth clock. When it was 0, SDA is left released (NACK).
- R5: From the ninth falling edge of an accepted byte, `scl_drive_low_o` stays 1 for any number of cycles until a release request. A write of any value other than 0xFF has no effect on it.
- R6: A pulse on `release_i`, or a cycle with `wr_en_i`=1 and `wr_data_i`=0xFF, during the hold clears `scl_drive_low_o` on the next clock edge.
- R7: `byte_done_o` is a one-cycle pulse raised in the cycle the hold begins, once for each accepted byte (the address and each data byte).
- R8: SDA rising while SCL is high pulses `stop_o` for one cycle, whether or not the transaction was addressed to this block, and returns the block to idle.
- R9: SDA falling while SCL is high (a start, including a repeated start in the middle of a byte) clears the bit count and re-enters the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| dev_addr_i | input | 7 | Own 7-bit target address |
| ack_en_i | input | 1 | 1 acknowledges accepted bytes, 0 answers NACK |
| release_i | input | 1 | Strobe that ends the SCL hold |
| wr_en_i | input | 1 | Data-register write enable |
| wr_data_i | input | 8 | Data-register write value; 0xFF ends the hold |
| rx_data_o | output | 8 | Last accepted byte |
| byte_done_o | output | 1 | One-cycle transfer-end event |
| stop_o | output | 1 | One-cycle stop-condition event |

## Verification
Bus-edge results reach the outputs about three clocks after the line moves: two synchronizer stages, one edge register and the state register. The bench model therefore holds every SCL phase for 16 clocks and samples ACK, `rx_data_o` and the event counters only after that phase has ended. Release requests are the exception. They go straight into the state register, so the bench drives `release_i` or the 0xFF write on a falling clock edge and checks `scl_drive_low_o` at the very next falling edge, one edge after the request. Event pulses are counted on every falling clock edge, which makes a missing, doubled or spurious `byte_done_o` or `stop_o` show up as a wrong count at the next checkpoint.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Two-line synchronizer and bus-condition detector.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_p;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign line_s[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_p <= '1;
        else        line_p <= line_s;
    end

    assign sda_s     = line_s[0];
    assign scl_rise  = line_s[1] & ~line_p[1];
    assign scl_fall  = ~line_s[1] & line_p[1];
    assign start_det = line_s[1] & line_p[1] & line_p[0] & ~line_s[0];
    assign stop_det  = line_s[1] & line_p[1] & ~line_p[0] & line_s[0];

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Receive controller: address compare, shift, ninth-clock answer, stretch.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              ack_en_i,
    input  logic              release_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              byte_done_o,
    output logic              stop_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W);
    localparam logic [DATA_W-1:0] REL_CODE = '1;

    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rx_q;
    logic              ack_q;
    logic              done_q;
    logic              stop_q;

    logic cnt_full, addr_hit, rel_req;
    logic shift_en, restart_cnt, enter_ack, leave_ack;

    assign cnt_full = (bit_cnt == CNT_LAST);
    assign addr_hit = (shreg[DATA_W-1 -: ADDR_W] == dev_addr_i) && !shreg[0];
    assign rel_req  = release_i || (wr_en_i && (wr_data_i == REL_CODE));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: if (scl_fall && cnt_full) state_d = addr_hit ? ST_ACK : ST_SKIP;
                ST_DATA: if (scl_fall && cnt_full) state_d = ST_ACK;
                ST_ACK:  if (scl_fall) state_d = ST_HOLD;
                ST_HOLD: if (rel_req) state_d = ST_DATA;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign shift_en    = ((state_q == ST_ADDR) || (state_q == ST_DATA)) && scl_rise
                         && !cnt_full && !start_det && !stop_det;
    assign restart_cnt = start_det || ((state_q == ST_HOLD) && (state_d == ST_DATA));
    assign enter_ack   = (state_d == ST_ACK) && (state_q != ST_ACK);
    assign leave_ack   = (state_q == ST_ACK) && (state_d == ST_HOLD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift path, captured byte, latched answer and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rx_q    <= '0;
            ack_q   <= 1'b0;
            done_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            done_q <= leave_ack;
            stop_q <= stop_det;
            if (restart_cnt) begin
                bit_cnt <= '0;
            end else if (shift_en) begin
                shreg   <= {shreg[DATA_W-2:0], sda_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (enter_ack) ack_q <= ack_en_i;
            if (leave_ack) rx_q  <= shreg;
        end
    end

    // Outputs
    always_comb begin
        scl_low_o   = (state_q == ST_HOLD);
        sda_low_o   = (state_q == ST_ACK) && ack_q;
        rx_data_o   = rx_q;
        byte_done_o = done_q;
        stop_o      = stop_q;
    end

endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              ack_en_i,
    input  logic              release_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              byte_done_o,
    output logic              stop_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .dev_addr_i  (dev_addr_i),
        .ack_en_i    (ack_en_i),
        .release_i   (release_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .scl_low_o   (scl_drive_low_o),
        .sda_low_o   (sda_drive_low_o),
        .rx_data_o   (rx_data_o),
        .byte_done_o (byte_done_o),
        .stop_o      (stop_o)
    );

endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_drive_low_o,
    input logic              sda_drive_low_o,
    input logic              ack_en_i,
    input logic              release_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              byte_done_o,
    input logic              stop_o
);
    logic rel_any;
    assign rel_any = release_i || (wr_en_i && (wr_data_i == {DATA_W{1'b1}}));

    a_r5_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low_o && !rel_any) |=> (scl_drive_low_o || stop_o));

    a_r6_release_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low_o && rel_any) |=> !scl_drive_low_o);

    a_r7_done_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |-> scl_drive_low_o);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |=> !byte_done_o);

    a_r8_stop_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    a_r4_ack_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> $past(ack_en_i));

    a_r4_no_ack_during_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_drive_low_o && scl_drive_low_o));

endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_drive_low_o (scl_drive_low_o),
    .sda_drive_low_o (sda_drive_low_o),
    .ack_en_i        (ack_en_i),
    .release_i       (release_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .byte_done_o     (byte_done_o),
    .stop_o          (stop_o)
);

// File: tb/test_i2c_tgt_rx.sv
module test_i2c_tgt_rx;
    localparam int H = 16;          // SCL phase length in system clocks
    localparam logic [6:0] OWN = 7'h5A;
    // Vector fields: [18:11] address byte, [10:3] data byte, [2] ack enable,
    // [1] address expected to match, [0] release mode (0 strobe, 1 write 0xFF)
    localparam int NVEC = 5;
    localparam logic [18:0] VEC [NVEC] = '{
        {8'hB4, 8'h3C, 1'b1, 1'b1, 1'b0},
        {8'hB4, 8'hA5, 1'b0, 1'b1, 1'b1},
        {8'h24, 8'h77, 1'b1, 1'b0, 1'b0},
        {8'hB5, 8'h11, 1'b1, 1'b0, 1'b0},
        {8'hB4, 8'h00, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_ln, sda_ln;
    logic scl_drive_low_o, sda_drive_low_o;
    logic ack_en_i = 1'b1, release_i = 1'b0, wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rx_data_o;
    logic byte_done_o, stop_o;

    int checks = 0, errors = 0;
    int n_done = 0, n_stop = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign scl_ln = scl_m & ~scl_drive_low_o;
    assign sda_ln = sda_m & ~sda_drive_low_o;

    i2c_tgt_rx i_i2c_tgt_rx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
        .dev_addr_i(OWN), .ack_en_i(ack_en_i), .release_i(release_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rx_data_o(rx_data_o),
        .byte_done_o(byte_done_o), .stop_o(stop_o)
    );

    always @(negedge clk) begin
        if (byte_done_o) n_done <= n_done + 1;
        if (stop_o)      n_stop <= n_stop + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;
        wait_clk(H);
        scl_m = 1'b1;
        while (scl_ln !== 1'b1) @(negedge clk);
        wait_clk(H / 2);
        seen = sda_ln;
        wait_clk(H / 2);
        scl_m = 1'b0;
        wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic do_release(input logic by_write);
        @(negedge clk);
        if (by_write) begin wr_en_i = 1'b1; wr_data_i = 8'hFF; end
        else          release_i = 1'b1;
        @(negedge clk);
        release_i = 1'b0; wr_en_i = 1'b0;
        chk(by_write ? "R6 release by 0xFF write" : "R6 release by strobe",
            int'(scl_drive_low_o), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic ak;
        int d0, s0;
        wait_clk(5);
        // R1: reset state
        chk("R1 scl drive", int'(scl_drive_low_o), 0);
        chk("R1 sda drive", int'(sda_drive_low_o), 0);
        chk("R1 events", int'({byte_done_o, stop_o}), 0);
        chk("R1 rx_data", int'(rx_data_o), 0);
        rst_n = 1'b1;
        wait_clk(5);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] ab, db, old_rx;
            logic en, hit, rm;
            {ab, db, en, hit, rm} = VEC[v];
            ack_en_i = en;
            old_rx = rx_data_o;
            d0 = n_done; s0 = n_stop;
            bus_start();
            send_byte(ab, ak);
            chk("R4/R3 address answer", int'(ak), int'(hit & en));
            chk("R7/R3 address byte_done", n_done - d0, int'(hit));
            chk("R5/R3 hold after address", int'(scl_drive_low_o), int'(hit));
            if (hit) begin
                chk("R2 address byte in rx_data", int'(rx_data_o), int'(ab));
                wait_clk(300);
                chk("R5 hold persists", int'(scl_drive_low_o), 1);
                @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h55;
                @(negedge clk); wr_en_i = 1'b0;
                wait_clk(3);
                chk("R5 non-0xFF write ignored", int'(scl_drive_low_o), 1);
                do_release(rm);
            end
            send_byte(db, ak);
            chk("R4/R3 data answer", int'(ak), int'(hit & en));
            chk("R2/R3 rx_data after data", int'(rx_data_o), int'(hit ? db : old_rx));
            chk("R7 byte_done count", n_done - d0, hit ? 2 : 0);
            if (hit) do_release(~rm);
            bus_stop();
            wait_clk(8);
            chk("R8 stop event", n_stop - s0, 1);
            chk("R8 idle after stop", int'({scl_drive_low_o, sda_drive_low_o}), 0);
        end

        // R9: repeated start in the middle of a data byte
        ack_en_i = 1'b1;
        d0 = n_done; s0 = n_stop;
        bus_start();
        send_byte(8'hB4, ak);
        chk("R9 first address acked", int'(ak), 1);
        do_release(1'b0);
        for (int i = 0; i < 3; i++) clk_bit(i[0], ak);
        bus_start();
        send_byte(8'hB4, ak);
        chk("R9 address after repeated start acked", int'(ak), 1);
        chk("R9 byte_done count", n_done - d0, 2);
        chk("R9 hold after repeated address", int'(scl_drive_low_o), 1);
        do_release(1'b1);
        send_byte(8'h81, ak);
        chk("R2 MSB-first 0x81", int'(rx_data_o), 8'h81);
        do_release(1'b0);
        bus_stop();
        wait_clk(8);
        chk("R8 stop after repeated start", n_stop - s0, 1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule